// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block moves data words from a write clock domain into an unrelated read clock domain through a dual-port memory. Each pointer is kept in binary for addressing and in Gray code for the crossing. Each side builds its own status flags from its local pointer and a synchronized copy of the far pointer. The write side drives a not-full flag and an active-low almost-full flag. The read side drives a single read-status flag and an active-low almost-empty flag.

A mode input, sampled while reset is held, picks one of two read behaviours. In fall-through mode the block pulls the oldest word into its registered output by itself, and the read-status flag means "a new word is valid on the output". In standard mode the read-status flag means "memory holds a word". The reader then asserts its enable to pull each word into the output register. The word held in the output register no longer counts toward the fill level, so in fall-through mode the block holds one word more than the memory depth. Both flag thresholds are also sampled during reset.

Top module: `xclk_fifo`

## Requirements
- R1: While reset is held and just after it is released, rdFlag is 0, fullN is 1, aeN is 0, afN is 1 (given afOffset < DEPTH) and rdData is all zeros.
- R2: In fall-through mode, a word written into an empty FIFO appears on rdData on the third rising rdClk edge after the write edge, and rdFlag rises on that same edge. rdFlag is still 0 after the first and second edges, and no read enable is needed.
- R3: In standard mode, rdFlag rises on the second rising rdClk edge after a write into an empty FIFO. rdData changes only on an edge where rdEn=1 and rdFlag was already 1 before that edge.
- R4: A read enable on an edge where rdFlag is 0 is ignored in both modes, and rdData keeps its previous word.
- R5: In fall-through mode, an edge with rdEn=1 and rdFlag=1 replaces rdData with the next stored word on that same edge if memory holds one. Otherwise rdFlag drops to 0 and rdData keeps the last word.
- R6: Words leave in the order they were accepted, with no loss or duplication.
- R7: The fill count excludes the word in the output register. In fall-through mode, DEPTH+1 words are accepted before fullN goes low.
- R8: fullN is 0 while the write-side count equals DEPTH, and it falls right after the write edge that fills the memory. A write while fullN is 0 is discarded and never appears on rdData.
- R9: aeN is 0 while the read-side count is at most the almost-empty offset, and 1 above it.
- R10: afN is 0 while the write-side count is at least DEPTH minus the almost-full offset, and 1 below it.
- R11: fwftMode, aeOffset and afOffset are sampled on clock edges while rstN is low and on the first edge after release. Changing the offsets between resets moves the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write domain clock |
| rdClk | input | 1 | Read domain clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| fwftMode | input | 1 | 1 = fall-through read, 0 = standard read; sampled during reset |
| aeOffset | input | $clog2(DEPTH)+1 | Almost-empty threshold; sampled during reset |
| afOffset | input | $clog2(DEPTH)+1 | Almost-full distance from DEPTH; sampled during reset |
| wrEn | input | 1 | Write request, taken on rising wrClk when fullN is 1 |
| wrData | input | WIDTH | Write data |
| fullN | output | 1 | 1 = room for a word, 0 = memory full |
| afN | output | 1 | Active-low almost-full |
| rdEn | input | 1 | Read request on rising rdClk |
| rdData | output | WIDTH | Registered read data |
| rdFlag | output | 1 | Fall-through: word valid on rdData; standard: word waiting in memory |
| aeN | output | 1 | Active-low almost-empty |

## Verification
The write-side flags are due just after the write edge itself. The effect of a read reaches the write side only after two further wrClk edges. The read side sees a write after two rdClk edges: the standard-mode flag is due after the second edge, and the fall-through load and flag after the third. The bench keeps rdClk at a fixed phase behind wrClk, so the first read edge after a write edge is always the first synchronizer edge. After each stimulus it counts the exact number of edges of the domain concerned and samples one nanosecond past the last one. Checks of values that depend on the far pointer wait at least three edges of the local clock before sampling.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic memWrite;  // write wrData into memory (wrClk domain)
    logic outLoad;   // load output register from memory (rdClk domain)
  } fifoStrobe_t;
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= '0;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xfifo_ctrl.sv
module xfifo_ctrl
  import xfifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          fwftMode,
  input  logic [PW-1:0] aeOffset,
  input  logic [PW-1:0] afOffset,
  input  logic          wrEn,
  input  logic          rdEn,
  output fifoStrobe_t   stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fullN,
  output logic          afN,
  output logic          aeN,
  output logic          rdFlag
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // configuration capture: while in reset and on first edge after it
  logic runW, runR;
  logic [PW-1:0] afOffW, aeOffR;
  logic modeR;

  always_ff @(posedge wrClk or negedge rstN)
    if (!rstN) runW <= 1'b0; else runW <= 1'b1;
  always_ff @(posedge rdClk or negedge rstN)
    if (!rstN) runR <= 1'b0; else runR <= 1'b1;

  always_ff @(posedge wrClk) if (!runW) afOffW <= afOffset;
  always_ff @(posedge rdClk) if (!runR) begin
    aeOffR <= aeOffset;
    modeR  <= fwftMode;
  end

  // write side
  logic [PW-1:0] wBin, wGray, rGraySyncW, rBinW, wrCount, wNext;
  logic wrAcc;

  assign wrCount = wBin - rBinW;
  assign wrAcc   = wrEn && (wrCount != DEPTH_P);
  assign wNext   = wBin + PW'(1);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin  <= '0;
      wGray <= '0;
    end else if (wrAcc) begin
      wBin  <= wNext;
      wGray <= (wNext >> 1) ^ wNext;
    end
  end

  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rToW (
    .clk(wrClk), .rstN(rstN), .d(rGray), .q(rGraySyncW)
  );
  assign rBinW = grayToBin(rGraySyncW);

  assign fullN = (wrCount != DEPTH_P);
  assign afN   = !(wrCount >= (DEPTH_P - afOffW));

  // read side
  logic [PW-1:0] rBin, rGray, wGraySyncR, wBinR, rdCount, rNext;
  logic memHas, ordy, rdLoad;

  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wToR (
    .clk(rdClk), .rstN(rstN), .d(wGray), .q(wGraySyncR)
  );
  assign wBinR   = grayToBin(wGraySyncR);
  assign rdCount = wBinR - rBin;
  assign memHas  = (rdCount != '0);
  assign rNext   = rBin + PW'(1);

  always_comb begin
    if (modeR) rdLoad = memHas && (!ordy || rdEn);
    else       rdLoad = memHas && rdEn;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rBin  <= '0;
      rGray <= '0;
      ordy  <= 1'b0;
    end else begin
      if (rdLoad) begin
        rBin  <= rNext;
        rGray <= (rNext >> 1) ^ rNext;
      end
      if (!modeR)      ordy <= 1'b0;
      else if (rdLoad) ordy <= 1'b1;
      else if (rdEn)   ordy <= 1'b0;
    end
  end

  assign rdFlag = modeR ? ordy : memHas;
  assign aeN    = !(rdCount <= aeOffR);

  assign stb.memWrite = wrAcc;
  assign stb.outLoad  = rdLoad;
  assign wrAddr = wBin[AW-1:0];
  assign rdAddr = rBin[AW-1:0];
endmodule

// File: rtl/xfifo_data.sv
module xfifo_data
  import xfifo_pkg::*;
#(
  parameter int WIDTH = 36,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  fifoStrobe_t      stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wrClk)
    if (stb.memWrite) mem[wrAddr] <= wrData;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (stb.outLoad) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xfifo_pkg::*;
#(
  parameter int WIDTH = 36,
  parameter int DEPTH = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             fwftMode,
  input  logic [PW-1:0]    aeOffset,
  input  logic [PW-1:0]    afOffset,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             fullN,
  output logic             afN,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             rdFlag,
  output logic             aeN
);
  fifoStrobe_t stb;
  logic [AW-1:0] wrAddr, rdAddr;

  xfifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
    .aeOffset(aeOffset), .afOffset(afOffset), .wrEn(wrEn), .rdEn(rdEn),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .afN(afN), .aeN(aeN), .rdFlag(rdFlag)
  );

  xfifo_data #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int WIDTH = 36
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             rstN,
  input logic             fwftMode,
  input logic             fullN,
  input logic             afN,
  input logic             rdEn,
  input logic [WIDTH-1:0] rdData,
  input logic             rdFlag,
  input logic             aeN
);
  // R10: a full memory is always past the almost-full threshold
  p_full_means_af_r10: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !afN);

  // R5: a valid fall-through word without a read stays put
  p_fwft_hold_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    (fwftMode && rdFlag && !rdEn) |=> (rdFlag && $stable(rdData)));

  // R4: standard mode with nothing waiting never changes the output
  p_std_hold_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && !rdFlag) |=> $stable(rdData));

  // R9: empty memory is always almost-empty
  p_std_empty_ae_r9: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fwftMode && !rdFlag) |-> !aeN);
endmodule

bind xclk_fifo xclk_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
  .fullN(fullN), .afN(afN), .rdEn(rdEn), .rdData(rdData),
  .rdFlag(rdFlag), .aeN(aeN)
);

// File: tb/tb_xclk_fifo.sv
module tb_xclk_fifo;
  localparam int WIDTH = 36;
  localparam int DEPTH = 16;
  localparam int PW = $clog2(DEPTH) + 1;

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic fwftMode = 1'b0;
  logic [PW-1:0] aeOffset = '0, afOffset = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic fullN, afN, rdFlag, aeN;
  logic [WIDTH-1:0] rdData;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 wrClk = ~wrClk;
  initial begin
    #7;
    forever #10 rdClk = ~rdClk;
  end

  xclk_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fwftMode(fwftMode),
    .aeOffset(aeOffset), .afOffset(afOffset), .wrEn(wrEn), .wrData(wrData),
    .fullN(fullN), .afN(afN), .rdEn(rdEn), .rdData(rdData),
    .rdFlag(rdFlag), .aeN(aeN)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrEdge(); @(posedge wrClk); #1; endtask
  task automatic rdEdge(); @(posedge rdClk); #1; endtask

  task automatic writeWord(input logic [WIDTH-1:0] d);
    wrData = d;
    wrEn = 1'b1;
    wrEdge();
    wrEn = 1'b0;
  endtask

  task automatic doReset(input logic m, input int x, input int y);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    fwftMode = m; aeOffset = PW'(x); afOffset = PW'(y);
    repeat (4) wrEdge();
    chk("R1 rdFlag in reset", 64'(rdFlag), 64'd0);
    rstN = 1'b1;
    wrEdge();
    chk("R1 rdFlag", 64'(rdFlag), 64'd0);
    chk("R1 fullN", 64'(fullN), 64'd1);
    chk("R1 aeN", 64'(aeN), 64'd0);
    chk("R1 afN", 64'(afN), 64'd1);
    chk("R1 rdData", 64'(rdData), 64'd0);
  endtask

  // R2 R4 R5 R6 R7 R8: fall-through latency, capacity and drain
  task automatic tFwft();
    doReset(1'b1, 2, 3);
    rdEn = 1'b1;
    repeat (3) rdEdge();
    chk("R4 fwft empty read flag", 64'(rdFlag), 64'd0);
    chk("R4 fwft empty read data", 64'(rdData), 64'd0);
    rdEn = 1'b0;
    writeWord(36'hC00);
    rdEdge();
    chk("R2 edge1 flag", 64'(rdFlag), 64'd0);
    rdEdge();
    chk("R2 edge2 flag", 64'(rdFlag), 64'd0);
    chk("R2 edge2 data", 64'(rdData), 64'd0);
    rdEdge();
    chk("R2 edge3 flag", 64'(rdFlag), 64'd1);
    chk("R2 edge3 data", 64'(rdData), 64'hC00);
    chk("R7 output word not counted (aeN)", 64'(aeN), 64'd0);
    repeat (3) wrEdge();
    for (int i = 1; i <= 15; i++) writeWord(36'hC00 + 36'(i));
    chk("R7 room after DEPTH words", 64'(fullN), 64'd1);
    writeWord(36'hC10);
    chk("R8 full after DEPTH+1 words", 64'(fullN), 64'd0);
    writeWord(36'hBAD);
    chk("R8 still full after dropped write", 64'(fullN), 64'd0);
    repeat (3) rdEdge();
    for (int i = 0; i <= 16; i++) begin
      chk("R6 drain order", 64'(rdData), 64'hC00 + 64'(i));
      chk("R5 flag during drain", 64'(rdFlag), 64'd1);
      rdEn = 1'b1;
      rdEdge();
      rdEn = 1'b0;
    end
    chk("R5 flag after last read", 64'(rdFlag), 64'd0);
    chk("R5 data kept after last read", 64'(rdData), 64'hC10);
    repeat (3) wrEdge();
    chk("R8 room after drain", 64'(fullN), 64'd1);
  endtask

  // R3 R4 R9: standard read latency and almost-empty
  task automatic tStd();
    doReset(1'b0, 1, 2);
    writeWord(36'hB01);
    rdEn = 1'b1;
    rdEdge();
    chk("R3 edge1 flag", 64'(rdFlag), 64'd0);
    chk("R4 edge1 read ignored", 64'(rdData), 64'd0);
    rdEdge();
    chk("R3 edge2 flag", 64'(rdFlag), 64'd1);
    chk("R4 edge2 read ignored", 64'(rdData), 64'd0);
    rdEdge();
    chk("R3 edge3 data", 64'(rdData), 64'hB01);
    chk("R3 edge3 flag", 64'(rdFlag), 64'd0);
    rdEn = 1'b0;
    writeWord(36'hB02);
    repeat (3) rdEdge();
    chk("R9 count 1 <= X", 64'(aeN), 64'd0);
    chk("R3 no read keeps data", 64'(rdData), 64'hB01);
    writeWord(36'hB03);
    repeat (3) rdEdge();
    chk("R9 count 2 > X", 64'(aeN), 64'd1);
    rdEn = 1'b1;
    rdEdge();
    rdEn = 1'b0;
    chk("R6 std order", 64'(rdData), 64'hB02);
    chk("R9 back to count 1", 64'(aeN), 64'd0);
  endtask

  // R10 R11: almost-full thresholds from two different resets
  task automatic tAlmostFull();
    doReset(1'b0, 0, 3);
    for (int i = 0; i < 12; i++) writeWord(36'h200 + 36'(i));
    chk("R10 count 12 below 13", 64'(afN), 64'd1);
    writeWord(36'h20C);
    chk("R10 count 13 reaches 13", 64'(afN), 64'd0);
    chk("R8 not yet full", 64'(fullN), 64'd1);
    doReset(1'b0, 0, 5);
    for (int i = 0; i < 10; i++) writeWord(36'h300 + 36'(i));
    chk("R11 count 10 below new 11", 64'(afN), 64'd1);
    writeWord(36'h30A);
    chk("R11 count 11 reaches new 11", 64'(afN), 64'd0);
    repeat (3) rdEdge();
    rdEn = 1'b1;
    rdEdge();
    rdEn = 1'b0;
    chk("R6 first out", 64'(rdData), 64'h300);
    repeat (3) wrEdge();
    chk("R10 after one read", 64'(afN), 64'd1);
  endtask

  initial begin
    tFwft();
    tStd();
    tAlmostFull();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule